// File: doc/BRIEF.md
# Programmable YUV-to-RGB Converter

This block converts display overlay pixels from YUV to 8-bit RGB. Each output channel is formed from a 3x3 fixed-point matrix applied to the unsigned 8-bit Y, U and V samples, plus an additive offset. The result is then rounded and clamped to 0..255. Two overlay windows are supported. Each has its own twelve-value coefficient bank and its own conversion enable. A pixel arrives with a window index and a YUV-format flag, and the block uses the coefficient bank of that window.

The coefficients are held in a small word-addressed 32-bit register file. At reset every bank holds the BT.601 studio-range set, so software only has to set the enables to get standard conversion. A pixel whose window is disabled, or whose format is not YUV, passes through unchanged with the same latency as a converted pixel. Downstream logic therefore sees one fixed latency.

Top module: `yuv_rgb_csc`

## Requirements
- R1: After reset the control word reads 0 (both windows disabled) and every coefficient bank reads the BT.601 set: words 0x000004A8, 0x04A80662, 0x1CBF1E6F, 0x081204A8, 0x00000000, 0x00321168, 0x000877CF, 0x002EB127 at bank offsets 0 to 28.
- R2: Matrix coefficient k (k = 0..8, row-major: row = output R/G/B, column = input Y/U/V) is a 13-bit two's-complement value with 10 fraction bits. It lives in bank word k/2: bits [12:0] for even k and bits [28:16] for odd k. Other bits of these words read 0.
- R3: The three offsets (R, G, B) are 22-bit two's-complement values with 12 fraction bits, held in bits [21:0] of bank words at byte offsets 20, 24 and 28. Bit 21 is the sign.
- R4: The control word sits at byte address 0x00. Bit 1 enables window 0 and bit 9 enables window 1. All other bits read 0.
- R5: Window w's bank starts at byte address 0x20 + 0x20*w. A converted channel equals floor((4*(c0*Y + c1*U + c2*V) + offset + 2048) / 4096), using that channel's row.
- R6: Rounding is to nearest: an offset of exactly +0.5 raises the result by one, and an offset of exactly -0.5 leaves it unchanged.
- R7: Converted results below 0 give 0 and results above 255 give 255.
- R8: If the pixel's window is disabled, or in_is_yuv is 0, then out_r/out_g/out_b equal in_y/in_u/in_v unchanged.
- R9: out_valid follows in_valid exactly three clock cycles later, with output data aligned to it, on both the converted path and the bypass path.
- R10: Each pixel uses the coefficient bank of the window given by in_win.
- R11: A register write changes only pixels accepted in later cycles. A pixel accepted in the same cycle as the write uses the old values.
- R12: Writes to unmapped word addresses, or to addresses whose two low bits are non-zero, change nothing, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_win | input | WIN_W | Window index of the input pixel |
| in_is_yuv | input | 1 | Pixel format is YUV |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Cb sample |
| in_v | input | 8 | Cr sample |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red result or passed-through Y |
| out_g | output | 8 | Green result or passed-through U |
| out_b | output | 8 | Blue result or passed-through V |

## Verification
The assertions assume that in_valid, in_win, in_is_yuv and the pixel samples are driven to known values from the first clock edge, and that in_win never names a window beyond NUM_WIN-1. The bench drives every input at time zero and uses only window indices 0 and 1. It also assumes that a register write and a pixel in the same cycle is legal, and that the pixel then sees the old state. The bench produces exactly that overlap in its write-ordering test. The latency and bypass properties follow each pixel's own entry-time decision, so the stimulus may change enables between pixels freely.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int PIX_W     = 8;
  localparam int COEF_W    = 13;
  localparam int COEF_FRAC = 10;
  localparam int OFF_W     = 22;
  localparam int OFF_FRAC  = 12;
  localparam int N_CH      = 3;
  localparam int N_MAT     = N_CH * N_CH;
  localparam int N_WORDS   = 8;
  localparam int PROD_W    = COEF_W + PIX_W + 1;
  localparam int ACC_W     = OFF_W + 6;
  localparam int ALIGN_SH  = OFF_FRAC - COEF_FRAC;
  localparam int HALF_W    = 16;

  typedef struct packed {
    logic [N_MAT-1:0][COEF_W-1:0] m;
    logic [N_CH-1:0][OFF_W-1:0]   off;
  } csc_bank_t;

  // BT.601 studio-range set, used as the reset image of every bank
  function automatic csc_bank_t bt601_bank();
    csc_bank_t b;
    b.m[0] = 13'h04A8; b.m[1] = 13'h0000; b.m[2] = 13'h0662;
    b.m[3] = 13'h04A8; b.m[4] = 13'h1E6F; b.m[5] = 13'h1CBF;
    b.m[6] = 13'h04A8; b.m[7] = 13'h0812; b.m[8] = 13'h0000;
    b.off[0] = 22'h321168;
    b.off[1] = 22'h0877CF;
    b.off[2] = 22'h2EB127;
    return b;
  endfunction

  // Register image of bank word i (zero-filled outside the fields)
  function automatic logic [31:0] bank_word(csc_bank_t b, int i);
    logic [31:0] w;
    w = '0;
    if (i < N_MAT / 2 + 1) begin
      w[COEF_W-1:0] = b.m[2*i];
      if (2*i + 1 < N_MAT) w[HALF_W +: COEF_W] = b.m[2*i+1];
    end else if (i < N_WORDS) begin
      w[OFF_W-1:0] = b.off[i - (N_MAT / 2 + 1)];
    end
    return w;
  endfunction

  // One matrix term: signed S2.10 coefficient times unsigned sample
  function automatic logic signed [PROD_W-1:0] mul_term(logic [COEF_W-1:0] c,
                                                        logic [PIX_W-1:0]  x);
    logic signed [PROD_W-1:0] cs, xs;
    cs = PROD_W'($signed(c));
    xs = PROD_W'($signed({1'b0, x}));
    return cs * xs;
  endfunction

  // Three terms aligned to the offset's fraction, plus offset and half LSB
  function automatic logic signed [ACC_W-1:0] acc_sum(logic signed [PROD_W-1:0] p0,
                                                      logic signed [PROD_W-1:0] p1,
                                                      logic signed [PROD_W-1:0] p2,
                                                      logic [OFF_W-1:0]         off);
    logic signed [ACC_W-1:0] a;
    a = ACC_W'(p0) + ACC_W'(p1) + ACC_W'(p2);
    a = (a <<< ALIGN_SH) + ACC_W'($signed(off));
    a = a + ACC_W'(1 << (OFF_FRAC - 1));
    return a;
  endfunction

  // Drop the fraction (floor) and clamp to the pixel range
  function automatic logic [PIX_W-1:0] round_sat(logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] q;
    logic signed [ACC_W-1:0] hi;
    hi = ACC_W'((1 << PIX_W) - 1);
    q  = a >>> OFF_FRAC;
    if (q < 0)       return '0;
    else if (q > hi) return '1;
    else             return q[PIX_W-1:0];
  endfunction

endpackage

// File: rtl/csc_regbank.sv
module csc_regbank
  import csc_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic [NUM_WIN-1:0]           win_en,
  output csc_bank_t [NUM_WIN-1:0]      banks
);

  localparam int WORD_W    = ADDR_W - 2;
  localparam int BANK_BASE = 8;
  localparam int EN_STRIDE = 8;
  localparam int EN_BIT0   = 1;
  localparam int N_MWORDS  = N_MAT / 2 + 1;

  logic [WORD_W-1:0] widx;
  logic              aligned;
  logic              hit_ctrl;

  assign widx     = reg_addr[ADDR_W-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign hit_ctrl = aligned && (widx == '0);

  logic      [NUM_WIN-1:0] en_q;
  csc_bank_t [NUM_WIN-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int w = 0; w < NUM_WIN; w++) bank_q[w] <= bt601_bank();
    end else if (reg_we && aligned) begin
      if (hit_ctrl) begin
        for (int w = 0; w < NUM_WIN; w++) en_q[w] <= reg_wdata[EN_BIT0 + EN_STRIDE*w];
      end
      for (int w = 0; w < NUM_WIN; w++) begin
        for (int i = 0; i < N_WORDS; i++) begin
          if (widx == WORD_W'(BANK_BASE + N_WORDS*w + i)) begin
            if (i < N_MWORDS) begin
              bank_q[w].m[2*i] <= reg_wdata[COEF_W-1:0];
              if (2*i + 1 < N_MAT) bank_q[w].m[2*i+1] <= reg_wdata[HALF_W +: COEF_W];
            end else begin
              bank_q[w].off[i - N_MWORDS] <= reg_wdata[OFF_W-1:0];
            end
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      for (int w = 0; w < NUM_WIN; w++) reg_rdata[EN_BIT0 + EN_STRIDE*w] = en_q[w];
    end
    for (int w = 0; w < NUM_WIN; w++) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (aligned && widx == WORD_W'(BANK_BASE + N_WORDS*w + i))
          reg_rdata = bank_word(bank_q[w], i);
      end
    end
  end

  assign win_en = en_q;
  assign banks  = bank_q;

endmodule

// File: rtl/csc_pipe.sv
module csc_pipe
  import csc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_conv,
  input  logic [N_CH-1:0][PIX_W-1:0]  in_pix,
  input  csc_bank_t                   bank,
  output logic                        out_valid,
  output logic [N_CH-1:0][PIX_W-1:0]  out_pix
);

  // Stage 1: products and offsets captured with the pixel
  logic                        s1_valid, s1_conv;
  logic [N_CH-1:0][PIX_W-1:0]  s1_pix;
  logic signed [PROD_W-1:0]    s1_prod [N_CH][N_CH];
  logic [N_CH-1:0][OFF_W-1:0]  s1_off;

  // Stage 2: aligned sums with rounding bias
  logic                        s2_valid, s2_conv;
  logic [N_CH-1:0][PIX_W-1:0]  s2_pix;
  logic signed [ACC_W-1:0]     s2_acc [N_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_conv   <= 1'b0;
      s2_valid  <= 1'b0;
      s2_conv   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_conv   <= in_conv;
      s2_valid  <= s1_valid;
      s2_conv   <= s1_conv;
      out_valid <= s2_valid;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    for (genvar t = 0; t < N_CH; t++) begin : g_term
      always_ff @(posedge clk) begin
        if (!rst_n) s1_prod[c][t] <= '0;
        else        s1_prod[c][t] <= mul_term(bank.m[N_CH*c + t], in_pix[t]);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_off[c]  <= '0;
        s1_pix[c]  <= '0;
        s2_acc[c]  <= '0;
        s2_pix[c]  <= '0;
        out_pix[c] <= '0;
      end else begin
        s1_off[c]  <= bank.off[c];
        s1_pix[c]  <= in_pix[c];
        s2_acc[c]  <= acc_sum(s1_prod[c][0], s1_prod[c][1], s1_prod[c][2], s1_off[c]);
        s2_pix[c]  <= s1_pix[c];
        out_pix[c] <= s2_conv ? round_sat(s2_acc[c]) : s2_pix[c];
      end
    end
  end

endmodule

// File: rtl/yuv_rgb_csc.sv
module yuv_rgb_csc
  import csc_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 8,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [WIN_W-1:0]  in_win,
  input  logic              in_is_yuv,
  input  logic [7:0]        in_y,
  input  logic [7:0]        in_u,
  input  logic [7:0]        in_v,
  output logic              out_valid,
  output logic [7:0]        out_r,
  output logic [7:0]        out_g,
  output logic [7:0]        out_b
);

  logic      [NUM_WIN-1:0] win_en;
  csc_bank_t [NUM_WIN-1:0] banks;
  csc_bank_t               sel_bank;
  logic                    conv_sel;
  logic [N_CH-1:0][PIX_W-1:0] pix_in, pix_out;

  csc_regbank #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .win_en    (win_en),
    .banks     (banks)
  );

  assign sel_bank = banks[in_win];
  assign conv_sel = win_en[in_win] && in_is_yuv;
  assign pix_in   = {in_v, in_u, in_y};

  csc_pipe pipe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_conv   (conv_sel),
    .in_pix    (pix_in),
    .bank      (sel_bank),
    .out_valid (out_valid),
    .out_pix   (pix_out)
  );

  assign out_r = pix_out[0];
  assign out_g = pix_out[1];
  assign out_b = pix_out[2];

endmodule

// File: rtl/yuv_rgb_csc_chk.sv
module yuv_rgb_csc_chk #(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [NUM_WIN-1:0] win_en,
  input logic               in_valid,
  input logic               conv_sel,
  input logic [7:0]         in_y,
  input logic [7:0]         in_u,
  input logic [7:0]         in_v,
  input logic               out_valid,
  input logic [7:0]         out_r,
  input logic [7:0]         out_g,
  input logic [7:0]         out_b
);

  localparam int WORD_W  = ADDR_W - 2;
  localparam int MAP_END = 8 + 8 * NUM_WIN;

  logic [2:0]  v_d, c_d;
  logic [23:0] p_d [3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_d <= '0;
      c_d <= '0;
      for (int i = 0; i < 3; i++) p_d[i] <= '0;
    end else begin
      v_d <= {v_d[1:0], in_valid};
      c_d <= {c_d[1:0], conv_sel};
      p_d[0] <= {in_y, in_u, in_v};
      p_d[1] <= p_d[0];
      p_d[2] <= p_d[1];
    end
  end

  logic [WORD_W-1:0]  widx;
  logic               wr_ctrl, wr_unmapped;
  logic [NUM_WIN-1:0] ctrl_bits;

  assign widx        = reg_addr[ADDR_W-1:2];
  assign wr_ctrl     = reg_we && reg_addr[1:0] == 2'b00 && widx == '0;
  assign wr_unmapped = reg_we && (reg_addr[1:0] != 2'b00 ||
                       (widx != '0 && widx < WORD_W'(8)) || widx >= WORD_W'(MAP_END));

  always_comb begin
    for (int w = 0; w < NUM_WIN; w++) ctrl_bits[w] = reg_wdata[1 + 8*w];
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_d[2]);

  assert_bypass_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_d[2]) |-> ({out_r, out_g, out_b} == p_d[2]));

  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (win_en == $past(ctrl_bits)));

  assert_unmapped_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(win_en));

endmodule

bind yuv_rgb_csc yuv_rgb_csc_chk #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .win_en    (win_en),
  .in_valid  (in_valid),
  .conv_sel  (conv_sel),
  .in_y      (in_y),
  .in_u      (in_u),
  .in_v      (in_v),
  .out_valid (out_valid),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b)
);

// File: tb/yuv_rgb_csc_tb_top.sv
module yuv_rgb_csc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [0:0]  in_win = '0;
  logic        in_is_yuv = 1'b0;
  logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  yuv_rgb_csc dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_win(in_win), .in_is_yuv(in_is_yuv),
    .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  typedef struct packed {
    logic [7:0] y, u, v;
    logic       w, yuv;
    logic [7:0] r, g, b;
  } vec_t;

  // Expected values worked out by hand from the R5 formula with BT.601 banks
  localparam vec_t VEC [8] = '{
    '{y:8'd16,  u:8'd128, v:8'd128, w:1'b0, yuv:1'b1, r:8'd0,   g:8'd0,   b:8'd0},
    '{y:8'd235, u:8'd128, v:8'd128, w:1'b0, yuv:1'b1, r:8'd255, g:8'd255, b:8'd255},
    '{y:8'd0,   u:8'd0,   v:8'd0,   w:1'b0, yuv:1'b1, r:8'd0,   g:8'd135, b:8'd0},
    '{y:8'd0,   u:8'd255, v:8'd0,   w:1'b0, yuv:1'b1, r:8'd0,   g:8'd36,  b:8'd238},
    '{y:8'd255, u:8'd0,   v:8'd255, w:1'b0, yuv:1'b1, r:8'd255, g:8'd225, b:8'd20},
    '{y:8'd128, u:8'd128, v:8'd128, w:1'b1, yuv:1'b1, r:8'd130, g:8'd130, b:8'd130},
    '{y:8'd12,  u:8'd34,  v:8'd56,  w:1'b0, yuv:1'b0, r:8'd12,  g:8'd34,  b:8'd56},
    '{y:8'd200, u:8'd17,  v:8'd99,  w:1'b1, yuv:1'b0, r:8'd200, g:8'd17,  b:8'd99}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // One pixel through the pipe; checks out_valid timing (R9) and returns RGB
  task automatic px(logic [7:0] y, u, v, logic w, logic yuv, output logic [23:0] rgb);
    @(negedge clk);
    in_valid = 1'b1; in_y = y; in_u = u; in_v = v; in_win = w; in_is_yuv = yuv;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 valid low at 2 cycles", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R9 valid high at 3 cycles", {31'd0, out_valid}, 32'd1);
    rgb = {out_r, out_g, out_b};
    @(negedge clk);
    check("R9 valid drops after one", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [23:0] rgb, rgb_a, rgb_b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset image
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    rd(8'h00, d); check("R1 ctrl reset", d, 32'h0);
    rd(8'h20, d); check("R1 bank0 word0", d, 32'h000004A8);
    rd(8'h28, d); check("R1 bank0 word2", d, 32'h1CBF1E6F);
    rd(8'h2C, d); check("R1 bank0 word3", d, 32'h081204A8);
    rd(8'h34, d); check("R1 bank0 offset R", d, 32'h00321168);
    rd(8'h5C, d); check("R1 bank1 offset B", d, 32'h002EB127);

    // R8 bypass while disabled: window 0 enable clear, YUV flagged
    px(8'd16, 8'd128, 8'd128, 1'b0, 1'b1, rgb);
    check("R8 disabled window passes through", {8'd0, rgb}, {8'd0, 8'd16, 8'd128, 8'd128});

    // R4 control word
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, d); check("R4 ctrl only bits 1 and 9", d, 32'h00000202);

    // R5 R7 R8 R10 vector table
    for (int i = 0; i < 8; i++) begin
      px(VEC[i].y, VEC[i].u, VEC[i].v, VEC[i].w, VEC[i].yuv, rgb);
      check($sformatf("R5/R7/R8/R10 vector %0d", i), {8'd0, rgb},
            {8'd0, VEC[i].r, VEC[i].g, VEC[i].b});
    end

    // R2 R3 custom bank for window 1
    wr(8'h40, 32'h00000000);
    wr(8'h44, 32'h00000400);   // c2 = 1.0 (R from V)
    wr(8'h48, 32'h00000400);   // c4 = 1.0 (G from U)
    wr(8'h4C, 32'h04000000);   // c7 = 1.0 (B from U)
    wr(8'h50, 32'h00000000);
    wr(8'h54, 32'h00000800);   // R offset +0.5
    wr(8'h58, 32'h003FF800);   // G offset -0.5
    wr(8'h5C, 32'h00000000);
    rd(8'h4C, d); check("R2 odd coefficient in high half", d, 32'h04000000);
    rd(8'h58, d); check("R3 negative offset readback", d, 32'h003FF800);

    // R6 rounding, R10 window 0 unaffected
    px(8'd10, 8'd20, 8'd30, 1'b1, 1'b1, rgb);
    check("R6 +0.5 rounds up, -0.5 holds", {8'd0, rgb}, {8'd0, 8'd31, 8'd20, 8'd20});
    px(8'd128, 8'd128, 8'd128, 1'b0, 1'b1, rgb);
    check("R10 window 0 keeps its own bank", {8'd0, rgb}, {8'd0, 8'd130, 8'd130, 8'd130});

    // R11 write in the same cycle as pixel A, pixel B follows
    @(negedge clk);
    in_valid = 1'b1; in_y = 8'd10; in_u = 8'd20; in_v = 8'd30; in_win = 1'b1; in_is_yuv = 1'b1;
    reg_we = 1'b1; reg_addr = 8'h54; reg_wdata = 32'h0;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rgb_a = {out_r, out_g, out_b};
    @(negedge clk);
    rgb_b = {out_r, out_g, out_b};
    check("R11 same-cycle pixel uses old offset", {24'd0, rgb_a[23:16]}, 32'd31);
    check("R11 later pixel uses new offset", {24'd0, rgb_b[23:16]}, 32'd30);

    // R2 field width: upper bits of halves drop
    wr(8'h4C, 32'hFFFFFFFF);
    rd(8'h4C, d); check("R2 field width 13 bits", d, 32'h1FFF1FFF);

    // R12 unmapped and misaligned writes
    wr(8'h04, 32'hFFFFFFFF);
    rd(8'h04, d); check("R12 unmapped reads zero", d, 32'h0);
    wr(8'h21, 32'h00000000);
    rd(8'h20, d); check("R12 misaligned write ignored", d, 32'h000004A8);
    wr(8'h00, 32'h00000002);
    rd(8'h00, d); check("R4 window 1 disabled", d, 32'h00000002);

    // R8 format flag and enable each force bypass
    px(8'd235, 8'd128, 8'd128, 1'b1, 1'b1, rgb);
    check("R8 window 1 disabled passes through", {8'd0, rgb}, {8'd0, 8'd235, 8'd128, 8'd128});
    px(8'd235, 8'd128, 8'd128, 1'b0, 1'b1, rgb);
    check("R7 window 0 still converts and clamps", {8'd0, rgb}, {8'd0, 8'd255, 8'd255, 8'd255});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule